// File: doc/BRIEF.md
# TLB Set Way-Match Comparator

This block decides which of the four ways of one translation-lookaside-buffer set holds a translation for the current request. A search engine elsewhere picks a set index and a page size to try. It then presents the set's four stored entries together with the request. One clock later the block returns a vector with one bit per way, plus flags that tell a clean single hit from a miss or an illegal duplicate.

A way matches only when every condition holds at once:

- the entry is valid;
- the entry is enabled for the hardware thread that issued the request;
- its translation ID equals the request's process ID, or is zero, which marks a page shared by all processes;
- its indirect flag equals the kind of search;
- its page-size code equals the size under test;
- its effective page number equals the request's number above the page offset of that size.

Duplicate matches are reported as an error. The block never picks a winner, so the search engine can raise its machine-check path.

Top module: `tlb_way_match`

## Requirements
- R1: A way whose valid bit is 0 never sets its hit bit.
- R2: A way matches only if bit `req_thread` of its thread-enable mask is 1.
- R3: A way's TID must equal `req_pid`, except that a TID of all zeros matches any PID.
- R4: A way's indirect flag must equal `req_ind`, where 0 means a direct search and 1 means an indirect search.
- R5: A way's 4-bit size code must equal `req_size`.
- R6: Page numbers are counted in 4 KB units. The comparison ignores low page-number bits by size code:
  - 0x1 (4 KB): 0 bits ignored
  - 0x3 (64 KB): 4 bits
  - 0x5 (1 MB): 8 bits
  - 0x7 (16 MB): 12 bits
  - 0x9 (256 MB): 16 bits
  - 0xA (1 GB): 18 bits
  - any other code: all bits are compared.
- R7: `hit_vec[i]` is 1 exactly when way i meets every match condition. It is registered, so it appears at the first rising edge after the inputs are presented.
- R8: `hit_one` is 1 exactly when one bit of `hit_vec` is set.
- R9: `hit_multi` is 1 exactly when two or more bits of `hit_vec` are set. No bit set is a miss, and then both flags are 0.
- R10: While `rst_n` is low at a rising edge, all outputs are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| way_valid | input | NUM_WAYS | Valid bit per way |
| way_epn | input | NUM_WAYS*EPN_W | Page number per way, way i at bits [i*EPN_W +: EPN_W] |
| way_size | input | NUM_WAYS*4 | Page-size code per way |
| way_tid | input | NUM_WAYS*PID_W | Translation ID per way (0 = global) |
| way_thd_mask | input | NUM_WAYS*THREADS | Thread-enable mask per way |
| way_ind | input | NUM_WAYS | Indirect flag per way |
| req_epn | input | EPN_W | Requested page number |
| req_pid | input | PID_W | Requesting process ID |
| req_thread | input | THR_W | Issuing hardware thread |
| req_size | input | 4 | Page-size code under test |
| req_ind | input | 1 | Search kind: 0 direct, 1 indirect |
| hit_vec | output | NUM_WAYS | Matching ways |
| hit_one | output | 1 | Exactly one way matched |
| hit_multi | output | 1 | Two or more ways matched |

## Verification
All three results are due at the first rising edge after the set and request are presented. Nothing is pipelined further, so the hit vector and both flags share that single cycle of latency. The bench drives each stimulus on a falling edge and samples at the next falling edge, half a period after the capturing edge. It changes no input in between. The reset check follows the same timing: reset and stimulus are applied together, and zeros are expected at the following falling edge.

// File: rtl/tlb_wm_pkg.sv
package tlb_wm_pkg;

    localparam int PG_CODE_W = 4;

    typedef enum logic [PG_CODE_W-1:0] {
        PG_4K   = 4'h1,
        PG_64K  = 4'h3,
        PG_1M   = 4'h5,
        PG_16M  = 4'h7,
        PG_256M = 4'h9,
        PG_1G   = 4'hA
    } pg_size_e;

    // Number of low page-number bits (4 KB units) that lie inside the page offset.
    function automatic int unsigned pg_offset_drop(logic [PG_CODE_W-1:0] code);
        case (code)
            PG_64K:  return 4;
            PG_1M:   return 8;
            PG_16M:  return 12;
            PG_256M: return 16;
            PG_1G:   return 18;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_size_mask.sv
module tlb_size_mask
    import tlb_wm_pkg::*;
#(
    parameter int EPN_W = 40
) (
    input  logic [PG_CODE_W-1:0] size_code,
    output logic [EPN_W-1:0]     epn_keep
);

    int unsigned drop;

    always_comb begin
        drop     = pg_offset_drop(size_code);
        epn_keep = {EPN_W{1'b1}} << drop;
    end

endmodule

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp
    import tlb_wm_pkg::*;
#(
    parameter int EPN_W   = 40,
    parameter int PID_W   = 14,
    parameter int THREADS = 4,
    parameter int THR_W   = 2
) (
    input  logic                 ent_valid,
    input  logic [EPN_W-1:0]     ent_epn,
    input  logic [PG_CODE_W-1:0] ent_size,
    input  logic [PID_W-1:0]     ent_tid,
    input  logic [THREADS-1:0]   ent_thd_mask,
    input  logic                 ent_ind,
    input  logic [EPN_W-1:0]     req_epn,
    input  logic [PID_W-1:0]     req_pid,
    input  logic [THR_W-1:0]     req_thread,
    input  logic [PG_CODE_W-1:0] req_size,
    input  logic                 req_ind,
    input  logic [EPN_W-1:0]     epn_keep,
    output logic                 match
);

    logic thd_ok;
    logic tid_ok;
    logic kind_ok;
    logic size_ok;
    logic epn_ok;

    always_comb begin
        thd_ok  = ent_thd_mask[req_thread];
        tid_ok  = (ent_tid == '0) || (ent_tid == req_pid);
        kind_ok = (ent_ind == req_ind);
        size_ok = (ent_size == req_size);
        epn_ok  = ((ent_epn ^ req_epn) & epn_keep) == '0;
        match   = ent_valid & thd_ok & tid_ok & kind_ok & size_ok & epn_ok;
    end

endmodule

// File: rtl/tlb_hit_summary.sv
module tlb_hit_summary #(
    parameter int NUM_WAYS = 4
) (
    input  logic [NUM_WAYS-1:0] hits,
    output logic                one,
    output logic                multi
);

    localparam int CNT_W = $clog2(NUM_WAYS + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            cnt = cnt + CNT_W'(hits[i]);
        end
        one   = (cnt == CNT_W'(1));
        multi = (cnt > CNT_W'(1));
    end

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_wm_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int EPN_W    = 40,
    parameter int PID_W    = 14,
    parameter int THREADS  = 4,
    localparam int THR_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WAYS-1:0]           way_valid,
    input  logic [NUM_WAYS*EPN_W-1:0]     way_epn,
    input  logic [NUM_WAYS*PG_CODE_W-1:0] way_size,
    input  logic [NUM_WAYS*PID_W-1:0]     way_tid,
    input  logic [NUM_WAYS*THREADS-1:0]   way_thd_mask,
    input  logic [NUM_WAYS-1:0]           way_ind,
    input  logic [EPN_W-1:0]              req_epn,
    input  logic [PID_W-1:0]              req_pid,
    input  logic [THR_W-1:0]              req_thread,
    input  logic [PG_CODE_W-1:0]          req_size,
    input  logic                          req_ind,
    output logic [NUM_WAYS-1:0]           hit_vec,
    output logic                          hit_one,
    output logic                          hit_multi
);

    typedef struct packed {
        logic [NUM_WAYS-1:0] hit;
        logic                one;
        logic                multi;
    } res_t;

    logic [EPN_W-1:0]    epn_keep;
    logic [NUM_WAYS-1:0] raw_hit;
    logic                raw_one;
    logic                raw_multi;
    res_t                res_d;
    res_t                res_q;

    tlb_size_mask #(.EPN_W(EPN_W)) u_mask (
        .size_code (req_size),
        .epn_keep  (epn_keep)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_way_cmp #(
            .EPN_W   (EPN_W),
            .PID_W   (PID_W),
            .THREADS (THREADS),
            .THR_W   (THR_W)
        ) u_cmp (
            .ent_valid    (way_valid[w]),
            .ent_epn      (way_epn[w*EPN_W +: EPN_W]),
            .ent_size     (way_size[w*PG_CODE_W +: PG_CODE_W]),
            .ent_tid      (way_tid[w*PID_W +: PID_W]),
            .ent_thd_mask (way_thd_mask[w*THREADS +: THREADS]),
            .ent_ind      (way_ind[w]),
            .req_epn      (req_epn),
            .req_pid      (req_pid),
            .req_thread   (req_thread),
            .req_size     (req_size),
            .req_ind      (req_ind),
            .epn_keep     (epn_keep),
            .match        (raw_hit[w])
        );
    end

    tlb_hit_summary #(.NUM_WAYS(NUM_WAYS)) u_sum (
        .hits  (raw_hit),
        .one   (raw_one),
        .multi (raw_multi)
    );

    always_comb begin
        res_d.hit   = raw_hit;
        res_d.one   = raw_one;
        res_d.multi = raw_multi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_vec   = res_q.hit;
    assign hit_one   = res_q.one;
    assign hit_multi = res_q.multi;

    // R8: single flag implies exactly one bit set
    a_r8_one_is_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit_one |-> ($countones(hit_vec) == 1));

    // R9: multi flag implies at least two bits set
    a_r9_multi_is_many: assert property (@(posedge clk) disable iff (!rst_n)
        hit_multi |-> ($countones(hit_vec) > 1));

    // R9: a miss raises neither flag
    a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> (!hit_one && !hit_multi));

    // R10: reset clears every output at the next edge
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (hit_vec == '0 && !hit_one && !hit_multi));

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk
        // R1: invalid way never hits
        a_r1_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            !way_valid[w] |=> !hit_vec[w]);
        // R2: disabled thread never hits
        a_r2_thread_off: assert property (@(posedge clk) disable iff (!rst_n)
            !way_thd_mask[w*THREADS + int'(req_thread)] |=> !hit_vec[w]);
        // R4: kind mismatch never hits
        a_r4_kind_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
            (way_ind[w] != req_ind) |=> !hit_vec[w]);
        // R5: size mismatch never hits
        a_r5_size_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
            (way_size[w*PG_CODE_W +: PG_CODE_W] != req_size) |=> !hit_vec[w]);
    end

endmodule

// File: tb/tlb_way_match_bench.sv
module tlb_way_match_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW   = 4;
    localparam int EW   = 40;
    localparam int PW   = 14;
    localparam int TH   = 4;
    localparam int TW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [EW-1:0] w_epn  [NW];
    logic [3:0]    w_size [NW];
    logic [PW-1:0] w_tid  [NW];
    logic [TH-1:0] w_thd  [NW];
    logic          w_val  [NW];
    logic          w_ind  [NW];

    logic [NW-1:0]    p_valid;
    logic [NW*EW-1:0] p_epn;
    logic [NW*4-1:0]  p_size;
    logic [NW*PW-1:0] p_tid;
    logic [NW*TH-1:0] p_thd;
    logic [NW-1:0]    p_ind;

    logic [EW-1:0] r_epn;
    logic [PW-1:0] r_pid;
    logic [TW-1:0] r_thr;
    logic [3:0]    r_size;
    logic          r_ind;

    logic [NW-1:0] hit_vec;
    logic          hit_one;
    logic          hit_multi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NW; i++) begin
            p_valid[i]         = w_val[i];
            p_epn[i*EW +: EW]  = w_epn[i];
            p_size[i*4 +: 4]   = w_size[i];
            p_tid[i*PW +: PW]  = w_tid[i];
            p_thd[i*TH +: TH]  = w_thd[i];
            p_ind[i]           = w_ind[i];
        end
    end

    tlb_way_match #(.NUM_WAYS(NW), .EPN_W(EW), .PID_W(PW), .THREADS(TH)) u_tlb_way_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .way_valid    (p_valid),
        .way_epn      (p_epn),
        .way_size     (p_size),
        .way_tid      (p_tid),
        .way_thd_mask (p_thd),
        .way_ind      (p_ind),
        .req_epn      (r_epn),
        .req_pid      (r_pid),
        .req_thread   (r_thr),
        .req_size     (r_size),
        .req_ind      (r_ind),
        .hit_vec      (hit_vec),
        .hit_one      (hit_one),
        .hit_multi    (hit_multi)
    );

    // R6: ignored low bits per size code
    function automatic int drop_bits(logic [3:0] c);
        case (c)
            4'h3: return 4;
            4'h5: return 8;
            4'h7: return 12;
            4'h9: return 16;
            4'hA: return 18;
            default: return 0;
        endcase
    endfunction

    function automatic logic way_exp(int i);
        logic [EW-1:0] diff;
        diff = (w_epn[i] ^ r_epn) >> drop_bits(r_size);
        return w_val[i] && w_thd[i][r_thr] && (w_tid[i] == 0 || w_tid[i] == r_pid)
            && (w_ind[i] == r_ind) && (w_size[i] == r_size) && (diff == 0);
    endfunction

    function automatic logic [NW-1:0] vec_exp();
        logic [NW-1:0] v;
        for (int i = 0; i < NW; i++) v[i] = way_exp(i);
        return v;
    endfunction

    task automatic check_out(string tag, logic [NW-1:0] ev);
        logic e1, em;
        e1 = ($countones(ev) == 1);
        em = ($countones(ev) > 1);
        checks++;
        if (hit_vec !== ev) begin
            fails++;
            $display("FAIL %s hit_vec actual %b expected %b", tag, hit_vec, ev);
        end
        checks++;
        if (hit_one !== e1) begin
            fails++;
            $display("FAIL %s/R8 hit_one actual %b expected %b", tag, hit_one, e1);
        end
        checks++;
        if (hit_multi !== em) begin
            fails++;
            $display("FAIL %s/R9 hit_multi actual %b expected %b", tag, hit_multi, em);
        end
    endtask

    // all ways exact copies of the request
    task automatic fill_match();
        for (int i = 0; i < NW; i++) begin
            w_val[i]  = 1'b1;
            w_epn[i]  = r_epn;
            w_size[i] = r_size;
            w_tid[i]  = r_pid;
            w_thd[i]  = '1;
            w_ind[i]  = r_ind;
        end
    endtask

    task automatic base_req(logic [3:0] sz);
        r_epn  = 40'hA5_1234_5678;
        r_pid  = 14'h1ABC;
        r_thr  = 2'd2;
        r_size = sz;
        r_ind  = 1'b0;
        fill_match();
    endtask

    task automatic only_way(int k);
        for (int i = 0; i < NW; i++) if (i != k) w_val[i] = 1'b0;
    endtask

    // R7: drive on falling edge, sample at the next falling edge
    task automatic run_dir(string tag, logic [NW-1:0] ev);
        @(negedge clk);
        check_out(tag, ev);
    endtask

    task automatic rand_step();
        logic [3:0] codes [6] = '{4'h1, 4'h3, 4'h5, 4'h7, 4'h9, 4'hA};
        r_epn  = {$urandom, $urandom} & {EW{1'b1}};
        r_pid  = PW'($urandom);
        r_thr  = TW'($urandom);
        r_size = ($urandom_range(0, 9) == 0) ? 4'($urandom) : codes[$urandom_range(0, 5)];
        r_ind  = 1'($urandom);
        fill_match();
        for (int i = 0; i < NW; i++) begin
            if ($urandom_range(0, 7) == 0) w_val[i] = 1'b0;
            if ($urandom_range(0, 5) == 0) w_thd[i] = TH'($urandom);
            case ($urandom_range(0, 5))
                0: w_tid[i] = '0;
                1: w_tid[i] = PW'($urandom);
                default: ;
            endcase
            if ($urandom_range(0, 7) == 0) w_ind[i] = ~r_ind;
            if ($urandom_range(0, 7) == 0) w_size[i] = 4'($urandom);
            case ($urandom_range(0, 3))
                0: w_epn[i] = r_epn ^ (EW'(1) << $urandom_range(0, 19));
                1: w_epn[i] = r_epn ^ (EW'(1) << $urandom_range(20, EW-1));
                default: ;
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd7301));
        base_req(4'h1);
        // R10: reset state
        repeat (3) @(negedge clk);
        check_out("R10 reset", 4'b0000);
        rst_n = 1'b1;

        @(negedge clk); base_req(4'h1);
        run_dir("R7 all ways match", 4'b1111);

        @(negedge clk); base_req(4'h1); only_way(2);
        run_dir("R1 single way valid", 4'b0100);

        @(negedge clk); base_req(4'h5); w_val[0] = 1'b0; w_val[3] = 1'b0;
        run_dir("R1 two invalid", 4'b0110);

        @(negedge clk); base_req(4'h1); only_way(1); w_thd[1] = 4'b1011;
        run_dir("R2 thread bit clear", 4'b0000);

        @(negedge clk); base_req(4'h1); only_way(1); w_thd[1] = 4'b0100;
        run_dir("R2 only issuing thread set", 4'b0010);

        @(negedge clk); base_req(4'h7); w_tid[0] = '0; w_tid[1] = 14'h0001;
        w_tid[2] = '0; w_val[3] = 1'b0; r_pid = 14'h2222; w_tid[3] = r_pid;
        run_dir("R3 global and private tid", 4'b0101);

        @(negedge clk); base_req(4'h1); only_way(3); w_ind[3] = 1'b1;
        run_dir("R4 indirect entry on direct search", 4'b0000);

        @(negedge clk); base_req(4'h9); r_ind = 1'b1; fill_match(); only_way(0);
        run_dir("R4 indirect search hit", 4'b0001);

        @(negedge clk); base_req(4'h3); w_size[1] = 4'h1; w_size[2] = 4'h5;
        run_dir("R5 size mismatch", 4'b1001);

        @(negedge clk); base_req(4'hA); w_epn[0] = r_epn ^ (EW'(1) << 17);
        w_epn[1] = r_epn ^ (EW'(1) << 18); w_epn[2] = r_epn ^ 40'h3FFFF; w_val[3] = 1'b0;
        run_dir("R6 1GB masks low 18", 4'b0101);

        @(negedge clk); base_req(4'h1); w_epn[0] = r_epn ^ 40'h1; only_way(0);
        run_dir("R6 4KB compares bit 0", 4'b0000);

        @(negedge clk); base_req(4'h3); w_epn[0] = r_epn ^ 40'hF;
        w_epn[1] = r_epn ^ 40'h10; w_val[2] = 1'b0; w_val[3] = 1'b0;
        run_dir("R6 64KB masks low 4", 4'b0001);

        @(negedge clk); base_req(4'h9); w_epn[0] = r_epn ^ 40'hFFFF;
        w_epn[1] = r_epn ^ 40'h10000; w_val[2] = 1'b0; w_val[3] = 1'b0;
        run_dir("R6 256MB masks low 16", 4'b0001);

        @(negedge clk); base_req(4'hF); w_epn[0] = r_epn ^ 40'h1; w_val[2] = 1'b0; w_val[3] = 1'b0;
        run_dir("R6 unknown code full compare", 4'b0010);

        // R10: reset during activity
        @(negedge clk); base_req(4'h1); rst_n = 1'b0;
        run_dir("R10 reset mid run", 4'b0000);
        rst_n = 1'b1;

        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            rand_step();
            @(negedge clk);
            check_out("R7 random", vec_exp());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R7 actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule